// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers thirty-two level-sensitive interrupt sources and steers each one onto one of fifteen interrupt lines toward a parent processor. Software sets an enable bit per source in a mask register and reads the live source levels in a status register. A 4-bit routing code per source selects its destination line. Code 0 leaves the source unconnected. Code v, for v from 1 to 15, sends it to line v-1. Because each source has exactly one code, it can reach at most one line. A parent can then give its lines different priorities, for example by keeping a timer source apart from heavy network traffic.

Software reaches the block through a plain 32-bit register bus with read strobe, write strobe and byte address. Each line is the registered OR of all enabled, active sources routed to it. A line stays high for as long as such a source stays high.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset the mask register, all four routing registers, the read data and every output line are zero.
- R2: The mask register at byte offset 0x00 is readable and writable. Bit i enables source i.
- R3: The status register at offset 0x04 reads the current level of source i in bit i. Writes to it change nothing.
- R4: Four routing registers sit at offsets 0x08, 0x0C, 0x10 and 0x14. The 4-bit code of source i is at offset 0x08 + 4*(3 - i/8), in bits 4*(i mod 8) to 4*(i mod 8)+3. So sources 0 to 7 are at 0x14 and sources 24 to 31 are at 0x08. Every routing register reads back what was written.
- R5: A source whose routing code is 0 drives no output line.
- R6: A source with routing code v in 1..15, enabled and high, drives output line v-1 and no other line.
- R7: A source whose mask bit is 0 has no effect on any output line.
- R8: Output lines are level based with one register stage. A line rises on the first clock edge after its qualifying source is high, stays high while that source stays high, and falls on the first edge after the source drops.
- R9: A line is high whenever at least one of the enabled, active sources routed to it is high.
- R10: A read of an unmapped or unaligned address returns zero. A write to one changes no register.
- R11: A write changes only the register it addresses, taking effect on the clock edge that samples the write strobe.
- R12: Read data appears on the clock edge that samples the read strobe and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevel | input | 32 | Interrupt source levels, active high |
| busAddr | input | 8 | Byte address of the register access |
| busWr | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRd | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| irqOut | output | 15 | Interrupt lines toward the parent, active high |

## Verification
A corrupt routing nibble shows up in two places one cycle after the source goes high. The wrong line rises, and reading the routing word back gives a value the bench did not write. The bench therefore checks each routed case both through readback and at the output lines. Sources are routed to 0x14 and 0x08, so a field packed in the wrong order moves the output to another line. A missing mask gate, or an output stage that latches instead of tracking the level, appears within one or two cycles of the source changing. Spot checks of several sources, lines and codes at the word boundaries cover the decode.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned IRQ_SRC_N = 32;
  localparam int unsigned IRQ_OUT_N = 15;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned FIELDS_PER_WORD = BUS_DW / FIELD_W;
  localparam int unsigned ROUTE_WORDS = IRQ_SRC_N / FIELDS_PER_WORD;
  localparam int unsigned ROUTE_IDX_W = (ROUTE_WORDS > 1) ? $clog2(ROUTE_WORDS) : 1;

  localparam logic [BUS_AW-1:0] OFS_MASK   = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_STAT   = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_ROUTE0 = 8'h08;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_MASK  = 2'd1,
    RD_STAT  = 2'd2,
    RD_ROUTE = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic                   wrMask;
    logic [ROUTE_WORDS-1:0] wrRoute;
    logic                   rdEn;
    rd_sel_e                rdSel;
    logic [ROUTE_IDX_W-1:0] rdWord;
  } reg_strobe_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output reg_strobe_t       strobe
);
  localparam logic [BUS_AW-1:0] ROUTE_END = BUS_AW'(OFS_ROUTE0 + 4 * ROUTE_WORDS);

  logic                   aligned;
  logic                   hitMask;
  logic                   hitStat;
  logic                   hitRoute;
  logic [ROUTE_IDX_W-1:0] routeIdx;

  always_comb begin
    aligned  = (busAddr[1:0] == 2'b00);
    hitMask  = aligned && (busAddr == OFS_MASK);
    hitStat  = aligned && (busAddr == OFS_STAT);
    hitRoute = aligned && (busAddr >= OFS_ROUTE0) && (busAddr < ROUTE_END);
    routeIdx = ROUTE_IDX_W'((busAddr - OFS_ROUTE0) >> 2);
  end

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    if (busWr) begin
      strobe.wrMask = hitMask;
      if (hitRoute) strobe.wrRoute[routeIdx] = 1'b1;
    end
    if (busRd) begin
      strobe.rdEn   = 1'b1;
      strobe.rdWord = routeIdx;
      if (hitMask)       strobe.rdSel = RD_MASK;
      else if (hitStat)  strobe.rdSel = RD_STAT;
      else if (hitRoute) strobe.rdSel = RD_ROUTE;
      else               strobe.rdSel = RD_NONE;
    end
  end
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  reg_strobe_t          strobe,
  input  logic [BUS_DW-1:0]    busWrData,
  input  logic [IRQ_SRC_N-1:0] srcLevel,
  output logic [BUS_DW-1:0]    busRdData,
  output logic [IRQ_OUT_N-1:0] irqOut
);
  logic [IRQ_SRC_N-1:0]                maskQ;
  logic [ROUTE_WORDS-1:0][BUS_DW-1:0]  routeQ;
  logic [IRQ_SRC_N-1:0][FIELD_W-1:0]   fieldOf;
  logic [IRQ_OUT_N-1:0][IRQ_SRC_N-1:0] routedTo;
  logic [IRQ_OUT_N-1:0]                hitNext;
  logic [IRQ_SRC_N-1:0]                liveSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else if (strobe.wrMask) maskQ <= busWrData[IRQ_SRC_N-1:0];
  end

  for (genvar w = 0; w < ROUTE_WORDS; w++) begin : g_route_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) routeQ[w] <= '0;
      else if (strobe.wrRoute[w]) routeQ[w] <= busWrData;
    end
  end

  // Source i lives in word (last - i/FIELDS_PER_WORD), nibble i mod FIELDS_PER_WORD
  for (genvar i = 0; i < IRQ_SRC_N; i++) begin : g_field
    assign fieldOf[i] =
      routeQ[ROUTE_WORDS-1-(i/FIELDS_PER_WORD)][FIELD_W*(i%FIELDS_PER_WORD) +: FIELD_W];
  end

  assign liveSrc = srcLevel & maskQ;

  for (genvar k = 0; k < IRQ_OUT_N; k++) begin : g_line
    for (genvar i = 0; i < IRQ_SRC_N; i++) begin : g_src
      assign routedTo[k][i] = (fieldOf[i] == FIELD_W'(k + 1));
    end
    assign hitNext[k] = |(liveSrc & routedTo[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= '0;
    else irqOut <= hitNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdData <= '0;
    else if (strobe.rdEn) begin
      case (strobe.rdSel)
        RD_MASK:  busRdData <= BUS_DW'(maskQ);
        RD_STAT:  busRdData <= BUS_DW'(srcLevel);
        RD_ROUTE: busRdData <= routeQ[strobe.rdWord];
        default:  busRdData <= '0;
      endcase
    end
  end

  p_line_needs_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> $past(|(srcLevel & maskQ)));

  p_unrouted_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (routeQ == '0) |=> (irqOut == '0));

  p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrMask |=> $stable(maskQ));

  p_route_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrRoute == '0) |=> $stable(routeQ));

  p_unmapped_read_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.rdSel == RD_NONE) |=> (busRdData == '0));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(busRdData));
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import irq_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_SRC_N-1:0] srcLevel,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic                 busWr,
  input  logic [BUS_DW-1:0]    busWrData,
  input  logic                 busRd,
  output logic [BUS_DW-1:0]    busRdData,
  output logic [IRQ_OUT_N-1:0] irqOut
);
  reg_strobe_t strobe;

  irq_route_ctrl uCtrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobe  (strobe)
  );

  irq_route_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .srcLevel  (srcLevel),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/lvl_irq_router_test.sv
`timescale 1ns/1ps
module lvl_irq_router_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcLevel = '0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRd = 1'b0;
  logic [31:0] busRdData;
  logic [14:0] irqOut;

  int total = 0;
  int fails = 0;
  logic [31:0] maskShadow = '0;
  logic [31:0] routeShadow [4];

  always #4 clk = ~clk;

  lvl_irq_router uut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .busAddr(busAddr),
    .busWr(busWr), .busWrData(busWrData), .busRd(busRd),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic setMask(input logic [31:0] m);
    maskShadow = m;
    busWrite(8'h00, m);
  endtask

  task automatic setField(input int i, input logic [3:0] v);
    int r;
    r = 3 - i / 8;
    routeShadow[r][4 * (i % 8) +: 4] = v;
    busWrite(8'(8 + 4 * r), routeShadow[r]);
  endtask

  task automatic clearRoutes();
    for (int r = 0; r < 4; r++) begin
      routeShadow[r] = '0;
      busWrite(8'(8 + 4 * r), 32'h0);
    end
  endtask

  function automatic logic [14:0] modelOut(input logic [31:0] src);
    logic [14:0] o;
    logic [3:0]  f;
    o = '0;
    for (int i = 0; i < 32; i++) begin
      f = routeShadow[3 - i / 8][4 * (i % 8) +: 4];
      if (f != 0 && src[i] && maskShadow[i]) o[f - 1] = 1'b1;
    end
    return o;
  endfunction

  task automatic driveAndCheck(input string tag, input logic [31:0] src);
    @(negedge clk);
    srcLevel = src;
    @(negedge clk);
    check(tag, 32'(irqOut), 32'(modelOut(src)));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irqOut after reset", 32'(irqOut), 32'h0);
    check("R1 rdData after reset", busRdData, 32'h0);
    busRead(8'h00, d); check("R1 mask after reset", d, 32'h0);
    for (int r = 0; r < 4; r++) begin
      busRead(8'(8 + 4 * r), d);
      check("R1 route word after reset", d, 32'h0);
    end
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    setMask(32'hA5A5_3C3C);
    busRead(8'h00, d); check("R2 mask readback", d, 32'hA5A5_3C3C);
    setMask(32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); srcLevel = 32'h1234_5678;
    busRead(8'h04, d); check("R3 status shows levels", d, 32'h1234_5678);
    busWrite(8'h04, 32'hFFFF_FFFF);
    busRead(8'h04, d); check("R3 status write ignored", d, 32'h1234_5678);
    busRead(8'h00, d); check("R3 status write leaves mask", d, 32'h0);
    @(negedge clk); srcLevel = '0;
  endtask

  task automatic t_route_rw();
    logic [31:0] d;
    for (int r = 0; r < 4; r++) begin
      routeShadow[r] = 32'h1357_9BDF ^ (32'h1111_1111 * r);
      busWrite(8'(8 + 4 * r), routeShadow[r]);
    end
    for (int r = 0; r < 4; r++) begin
      busRead(8'(8 + 4 * r), d);
      check("R4 route word readback", d, 32'h1357_9BDF ^ (32'h1111_1111 * r));
    end
    clearRoutes();
  endtask

  task automatic t_route_map();
    int srcs [7] = '{0, 7, 8, 15, 23, 24, 31};
    logic [3:0] codes [7] = '{4'd1, 4'd15, 4'd3, 4'd8, 4'd12, 4'd2, 4'd14};
    setMask(32'hFFFF_FFFF);
    for (int n = 0; n < 7; n++) begin
      clearRoutes();
      setField(srcs[n], codes[n]);
      driveAndCheck("R4 R6 single source on its line", 32'h1 << srcs[n]);
      check("R6 exact line", 32'(irqOut), 32'h1 << (codes[n] - 1));
      @(negedge clk); srcLevel = '0;
    end
    clearRoutes();
    setField(31, 4'd5);
    driveAndCheck("R4 packing: source 31 word 0x08", 32'h8000_0000);
    check("R4 source 31 low nibble top", 32'(irqOut), 32'h10);
    @(negedge clk); srcLevel = '0;
    clearRoutes();
  endtask

  task automatic t_disconnect();
    setMask(32'hFFFF_FFFF);
    clearRoutes();
    setField(9, 4'd0);
    driveAndCheck("R5 code zero drives nothing", 32'hFFFF_FFFF);
    check("R5 all lines low", 32'(irqOut), 32'h0);
    @(negedge clk); srcLevel = '0;
  endtask

  task automatic t_masked();
    clearRoutes();
    setField(12, 4'd6);
    setMask(32'hFFFF_EFFF);
    driveAndCheck("R7 masked source ignored", 32'h0000_1000);
    check("R7 line stays low", 32'(irqOut), 32'h0);
    setMask(32'hFFFF_FFFF);
    @(negedge clk);
    check("R7 unmasking raises line", 32'(irqOut), 32'h20);
    @(negedge clk); srcLevel = '0;
  endtask

  task automatic t_level();
    clearRoutes();
    setField(20, 4'd10);
    setMask(32'hFFFF_FFFF);
    @(negedge clk); srcLevel = 32'h0010_0000;
    #1 check("R8 no change before edge", 32'(irqOut), 32'h0);
    @(negedge clk); check("R8 rises after one edge", 32'(irqOut), 32'h200);
    repeat (4) @(negedge clk);
    check("R8 held while level high", 32'(irqOut), 32'h200);
    srcLevel = '0;
    @(negedge clk); check("R8 falls after drop", 32'(irqOut), 32'h0);
  endtask

  task automatic t_or();
    clearRoutes();
    setField(2, 4'd7);
    setField(29, 4'd7);
    setField(16, 4'd1);
    setMask(32'hFFFF_FFFF);
    driveAndCheck("R9 two sources one line", 32'h2001_0004);
    driveAndCheck("R9 one of two dropped", 32'h2000_0000);
    check("R9 line 6 still high", 32'(irqOut), 32'h40);
    driveAndCheck("R9 both dropped", 32'h0);
    clearRoutes();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    busRead(8'h18, d); check("R10 read past routes", d, 32'h0);
    busRead(8'h03, d); check("R10 unaligned read", d, 32'h0);
    busRead(8'hFC, d); check("R10 high address read", d, 32'h0);
    setMask(32'h0F0F_0F0F);
    busWrite(8'h18, 32'hFFFF_FFFF);
    busWrite(8'h01, 32'hFFFF_FFFF);
    busRead(8'h00, d); check("R10 mask untouched", d, 32'h0F0F_0F0F);
    for (int r = 0; r < 4; r++) begin
      busRead(8'(8 + 4 * r), d);
      check("R10 routes untouched", d, routeShadow[r]);
    end
  endtask

  task automatic t_isolation();
    logic [31:0] d;
    setMask(32'h1234_ABCD);
    for (int r = 0; r < 4; r++) begin
      routeShadow[r] = 32'h0102_0304 + r;
      busWrite(8'(8 + 4 * r), routeShadow[r]);
    end
    routeShadow[1] = 32'hDEAD_BEEF;
    busWrite(8'h0C, 32'hDEAD_BEEF);
    busRead(8'h00, d); check("R11 mask unchanged", d, 32'h1234_ABCD);
    for (int r = 0; r < 4; r++) begin
      busRead(8'(8 + 4 * r), d);
      check("R11 only addressed word changed", d, routeShadow[r]);
    end
    busRead(8'h0C, d);
    repeat (3) @(negedge clk);
    check("R12 read data held", busRdData, 32'hDEAD_BEEF);
    clearRoutes();
  endtask

  initial begin
    for (int r = 0; r < 4; r++) routeShadow[r] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_reset();
    t_mask_rw();
    t_status();
    t_route_rw();
    t_route_map();
    t_disconnect();
    t_masked();
    t_level();
    t_or();
    t_unmapped();
    t_isolation();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule